// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter with eight analog inputs. It drives a channel select and a trial DAC code and reads back one comparator bit. It settles the result one bit per step, most significant bit first, and stores each finished code in a result register for that channel. The analog comparator and DAC sit outside the block.

Software controls it through a small register port. A control word at address 0 holds the start/busy bit, the completion flag, the interrupt enable, the mode and channel fields and the step-time divider. The result of channel `c` is read at address `NCH + c`. A conversion can be started by a software write, by a rising edge on the timer trigger or by a rising edge on the external trigger. Single mode converts one channel once. Scan mode cycles through channels 0 up to the selected last channel until software stops it.

Top module: `sar_seq_top`

## Requirements
- R1: With an ideal comparator (`cmp_i` = 1 when the analog input is at or above `dac_code_o`), every stored result equals the channel's input code exactly. The first trial code of each conversion is 0x200, and bits are decided from bit 9 down to bit 0.
- R2: The result of channel `c` is stored in its own register, readable at address 8+c in bits [9:0]. No other channel's register changes.
- R3: Control word layout: bit0 start/busy, bit1 completion flag, bit2 interrupt enable, bit3 scan mode, bits[6:4] channel, bits[11:8] divider. In single mode (bit3=0) the selected channel is converted once. Busy then clears by itself and the flag is set.
- R4: In scan mode, channels 0 up to the channel field are converted in ascending order, and each result is written as it finishes. The flag is set at the end of each full pass. Conversion keeps cycling while busy stays 1.
- R5: A conversion starts on a control write with bit0=1, on a rising edge of `tim_trig_i`, or on a rising edge of `ext_trig_i`, each accepted while idle.
- R6: Trigger edges that arrive while busy is 1 are ignored and do not cause a later conversion.
- R7: Writing bit0=0 while busy aborts the conversion: busy goes to 0, no result is written and the flag is not set.
- R8: While busy, writes to the mode, channel and divider fields are ignored. While idle, a single write may set new fields together with bit0=1, and the conversion uses the new values.
- R9: Each bit step lasts divider+1 clock cycles. In single mode, busy reads 1 for exactly 10*(divider+1)+2 cycles after the start write.
- R10: The flag is cleared only by writing bit1=0 after a read of the control word that returned the flag as 1. `irq_o` is high exactly while the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| tim_trig_i | input | 1 | Timer start trigger, asynchronous |
| ext_trig_i | input | 1 | External start trigger, asynchronous |
| cmp_i | input | 1 | Comparator: analog input >= DAC code |
| dac_code_o | output | 10 | Trial code to the DAC |
| chan_sel_o | output | 3 | Analog multiplexer select |
| irq_o | output | 1 | Conversion-complete interrupt request |

## Verification
The assertions assume that `cmp_i` is a pure function of the currently selected channel and the current DAC code. They also assume that the register strobes are single-cycle and carry no unknown values. The bench drives the comparator from an ideal model indexed by `chan_sel_o`. It changes stored input levels only while the block is idle, so a conversion always sees a constant input. Triggers are held for several cycles so that the synchroniser sees every edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_FLAG  = 1;
  localparam int unsigned CTRL_IE    = 2;
  localparam int unsigned CTRL_SCAN  = 3;
  localparam int unsigned CTRL_CH_LO = 4;
  localparam int unsigned CTRL_DV_LO = 8;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SW,
    SRC_TRIG
  } start_src_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int unsigned RES  = 10,
  parameter int unsigned DIVW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            cmp_i,
  output logic [RES-1:0]  dac_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [RES-1:0]  result_o
);
  localparam int unsigned BW = $clog2(RES);

  logic [RES-1:0]  trial_q;
  logic [BW-1:0]   bit_q;
  logic [DIVW-1:0] cnt_q;
  logic            busy_q;
  logic            done_q;
  logic [RES-1:0]  res_q;
  logic [RES-1:0]  decided;

  always_comb begin
    decided = trial_q;
    if (!cmp_i) decided[bit_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q  <= 1'b0;
        trial_q <= '0;
      end else if (start_i) begin
        busy_q  <= 1'b1;
        trial_q <= RES'(1) << (RES-1);
        bit_q   <= BW'(RES-1);
        cnt_q   <= '0;
      end else if (busy_q) begin
        if (cnt_q == div_i) begin
          cnt_q <= '0;
          if (bit_q == '0) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            res_q   <= decided;
            trial_q <= '0;
          end else begin
            trial_q                 <= decided;
            trial_q[bit_q - 1'b1]   <= 1'b1;
            bit_q                   <= bit_q - 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dac_o    = trial_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned RES = 10,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CHW-1:0] wch_i,
  input  logic [RES-1:0] wdata_i,
  input  logic [CHW-1:0] rch_i,
  output logic [RES-1:0] rdata_o
);
  logic [RES-1:0] res_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       res_q[g] <= '0;
      else if (we_i && wch_i == CHW'(g)) res_q[g] <= wdata_i;
    end
  end

  assign rdata_o = res_q[rch_i];
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned RES    = 10,
  parameter int unsigned DIVW   = 4,
  parameter int unsigned DW     = 16,
  parameter int unsigned STAGES = 2,
  localparam int unsigned CHW   = $clog2(NCH),
  localparam int unsigned AW    = CHW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic           reg_re_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic           tim_trig_i,
  input  logic           ext_trig_i,
  input  logic           cmp_i,
  output logic [RES-1:0] dac_code_o,
  output logic [CHW-1:0] chan_sel_o,
  output logic           irq_o
);
  localparam int unsigned NTRIG = 2;

  logic             busy_q, flag_q, armed_q, ie_q, scan_q, go_q;
  logic [CHW-1:0]   chan_q, cur_ch_q;
  logic [DIVW-1:0]  div_q;
  logic [NTRIG-1:0] trig_raw, trig_rise;
  logic             trig_any, ctrl_wr, ctrl_rd, abort, eng_busy, eng_done;
  logic             res_we, flag_set, flag_clr, pass_end;
  logic [RES-1:0]   eng_result, bank_rdata;
  logic [CHW-1:0]   wr_ch;
  start_src_e       src;

  assign trig_raw = {ext_trig_i, tim_trig_i};

  for (genvar t = 0; t < NTRIG; t++) begin : g_trig
    sar_edge_sync #(.STAGES(STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(trig_raw[t]),
      .rise_o (trig_rise[t])
    );
  end

  assign trig_any = |trig_rise;
  assign ctrl_wr  = reg_we_i && (reg_addr_i == '0);
  assign ctrl_rd  = reg_re_i && (reg_addr_i == '0);
  assign abort    = busy_q && ctrl_wr && !reg_wdata_i[CTRL_START];
  assign pass_end = !scan_q || (cur_ch_q == chan_q);
  assign res_we   = busy_q && eng_done && !abort;
  assign flag_set = res_we && pass_end;
  assign flag_clr = ctrl_wr && !reg_wdata_i[CTRL_FLAG] && armed_q;

  always_comb begin
    src = SRC_NONE;
    if (!busy_q) begin
      if (ctrl_wr && reg_wdata_i[CTRL_START]) src = SRC_SW;
      else if (trig_any)                      src = SRC_TRIG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      go_q     <= 1'b0;
      ie_q     <= 1'b0;
      scan_q   <= 1'b0;
      chan_q   <= '0;
      div_q    <= '0;
      cur_ch_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (ctrl_wr) ie_q <= reg_wdata_i[CTRL_IE];
      if (!busy_q && ctrl_wr) begin
        scan_q <= reg_wdata_i[CTRL_SCAN];
        chan_q <= reg_wdata_i[CTRL_CH_LO +: CHW];
        div_q  <= reg_wdata_i[CTRL_DV_LO +: DIVW];
      end
      unique case (src)
        SRC_SW: begin
          busy_q   <= 1'b1;
          go_q     <= 1'b1;
          cur_ch_q <= reg_wdata_i[CTRL_SCAN] ? '0 : reg_wdata_i[CTRL_CH_LO +: CHW];
        end
        SRC_TRIG: begin
          busy_q   <= 1'b1;
          go_q     <= 1'b1;
          cur_ch_q <= scan_q ? '0 : chan_q;
        end
        default: begin
          if (abort) begin
            busy_q <= 1'b0;
          end else if (res_we) begin
            if (!scan_q) begin
              busy_q <= 1'b0;
            end else begin
              go_q     <= 1'b1;
              cur_ch_q <= pass_end ? '0 : cur_ch_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (flag_set) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (flag_clr) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (ctrl_rd && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  sar_step_engine #(.RES(RES), .DIVW(DIVW)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .abort_i (abort),
    .div_i   (div_q),
    .cmp_i   (cmp_i),
    .dac_o   (dac_code_o),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .result_o(eng_result)
  );

  assign wr_ch = cur_ch_q;

  sar_result_bank #(.NCH(NCH), .RES(RES)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (res_we),
    .wch_i  (wr_ch),
    .wdata_i(eng_result),
    .rch_i  (reg_addr_i[CHW-1:0]),
    .rdata_o(bank_rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[AW-1]) begin
      reg_rdata_o = DW'(bank_rdata);
    end else if (reg_addr_i == '0) begin
      reg_rdata_o[CTRL_START]            = busy_q;
      reg_rdata_o[CTRL_FLAG]             = flag_q;
      reg_rdata_o[CTRL_IE]               = ie_q;
      reg_rdata_o[CTRL_SCAN]             = scan_q;
      reg_rdata_o[CTRL_CH_LO +: CHW]     = chan_q;
      reg_rdata_o[CTRL_DV_LO +: DIVW]    = div_q;
    end
  end

  assign chan_sel_o = cur_ch_q;
  assign irq_o      = flag_q & ie_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned RES  = 10,
  parameter int unsigned DIVW = 4,
  parameter int unsigned CHW  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_q,
  input logic            flag_q,
  input logic            scan_q,
  input logic            abort,
  input logic            eng_busy,
  input logic            irq_o,
  input logic [CHW-1:0]  chan_q,
  input logic [CHW-1:0]  cur_ch_q,
  input logic [DIVW-1:0] div_q,
  input logic [RES-1:0]  dac_code_o
);
  AST_SAR_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_busy) |-> dac_code_o == (RES'(1) << (RES-1))); // R1

  AST_SINGLE_CH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !scan_q) |-> $stable(cur_ch_q)); // R3

  AST_SCAN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && scan_q && !$stable(cur_ch_q))
      |-> (cur_ch_q == CHW'($past(cur_ch_q) + 1'b1) || cur_ch_q == '0)); // R4

  AST_ABORT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(abort) |-> (!$rose(flag_q) && !busy_q)); // R7

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(chan_q) && $stable(div_q) && $stable(scan_q))); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q); // R10
endmodule

bind sar_seq_top sar_seq_chk #(.RES(RES), .DIVW(DIVW), .CHW(CHW)) i_sar_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_q    (busy_q),
  .flag_q    (flag_q),
  .scan_q    (scan_q),
  .abort     (abort),
  .eng_busy  (eng_busy),
  .irq_o     (irq_o),
  .chan_q    (chan_q),
  .cur_ch_q  (cur_ch_q),
  .div_q     (div_q),
  .dac_code_o(dac_code_o)
);

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        tim_trig_i = 1'b0, ext_trig_i = 1'b0;
  logic        cmp_i;
  logic [9:0]  dac_code_o;
  logic [2:0]  chan_sel_o;
  logic        irq_o;
  logic [9:0]  vin [8];
  int          n_chk = 0, n_fail = 0;
  int          scan_bad = 0;
  logic        scan_mon = 1'b0;
  logic [2:0]  prev_ch;

  always #5 clk_i = ~clk_i;

  assign cmp_i = (vin[chan_sel_o] >= dac_code_o);

  sar_seq_top i_sar_seq_top (.*);

  function automatic logic [15:0] ctrl_word(bit start, bit ie, bit scan, int ch, int dv);
    return {4'b0, 4'(dv), 1'b0, 3'(ch), scan, ie, 1'b0, start};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'(addr); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = '0;
  endtask

  task automatic rd(int addr, output logic [15:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = 4'(addr);
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0; reg_addr_i = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (reg_rdata_o[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    rd(0, d);
    wr(0, {d[15:2], 2'b00});
  endtask

  always @(negedge clk_i) begin
    if (scan_mon && reg_rdata_o[0] && chan_sel_o != prev_ch) begin
      if (!(chan_sel_o == prev_ch + 3'd1 || chan_sel_o == 3'd0)) scan_bad++;
    end
    prev_ch <= chan_sel_o;
  end

  initial begin
    #(1_500_000ns);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [9:0]  keep4;
    int cyc;
    void'($urandom(32'd7531));
    for (int i = 0; i < 8; i++) vin[i] = 10'($urandom);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(reg_rdata_o == 16'h0 && !irq_o && dac_code_o == '0, "reset", reg_rdata_o, 0);

    // random single conversions, including code extremes
    for (int i = 0; i < 24; i++) begin
      int ch = $urandom_range(0, 7);
      int dv = $urandom_range(0, 3);
      bit ie = 1'($urandom);
      if (i == 0) vin[ch] = 10'h000;
      else if (i == 1) vin[ch] = 10'h3FF;
      else vin[ch] = 10'($urandom);
      wr(0, ctrl_word(1, ie, 0, ch, dv));
      wait_idle(cyc);
      chk(cyc == 10 * (dv + 1) + 2, "R9 busy length", cyc, 10 * (dv + 1) + 2);
      chk(reg_rdata_o[1] == 1'b1, "R3 flag set", reg_rdata_o[1], 1);
      chk(irq_o == ie, "R10 irq", irq_o, ie);
      rd(8 + ch, d);
      chk(d[9:0] == vin[ch], "R1 R2 result", d, vin[ch]);
      clear_flag();
      chk(reg_rdata_o[1] == 1'b0 && !irq_o, "R10 flag cleared", reg_rdata_o[1], 0);
    end

    // flag not cleared by a write without a prior read
    wr(0, ctrl_word(1, 1, 0, 2, 0));
    wait_idle(cyc);
    wr(0, ctrl_word(0, 1, 0, 2, 0));
    chk(reg_rdata_o[1] == 1'b1 && irq_o, "R10 no clear without read", reg_rdata_o[1], 1);
    clear_flag();
    chk(reg_rdata_o[1] == 1'b0, "R10 clear after read", reg_rdata_o[1], 0);

    // timer trigger and external trigger start
    wr(0, ctrl_word(0, 0, 0, 5, 1));
    vin[5] = 10'($urandom);
    @(negedge clk_i); tim_trig_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(reg_rdata_o[0] == 1'b1, "R5 timer start", reg_rdata_o[0], 1);
    tim_trig_i = 1'b0;
    wait_idle(cyc);
    rd(13, d);
    chk(d[9:0] == vin[5], "R5 timer result", d, vin[5]);
    clear_flag();
    wr(0, ctrl_word(0, 0, 0, 6, 0));
    vin[6] = 10'($urandom);
    @(negedge clk_i); ext_trig_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(reg_rdata_o[0] == 1'b1, "R5 external start", reg_rdata_o[0], 1);
    ext_trig_i = 1'b0;
    wait_idle(cyc);
    rd(14, d);
    chk(d[9:0] == vin[6], "R5 external result", d, vin[6]);
    clear_flag();

    // trigger while busy ignored; config writes while busy ignored
    vin[1] = 10'($urandom);
    wr(0, ctrl_word(1, 0, 0, 1, 15));
    repeat (10) @(negedge clk_i);
    ext_trig_i = 1'b1;
    wr(0, ctrl_word(1, 0, 1, 4, 3));
    repeat (5) @(negedge clk_i);
    ext_trig_i = 1'b0;
    wait_idle(cyc);
    chk(cyc > 100, "R8 divider held", cyc, 162);
    repeat (10) @(negedge clk_i);
    chk(reg_rdata_o[0] == 1'b0, "R6 trigger ignored", reg_rdata_o[0], 0);
    chk(reg_rdata_o[6:3] == 4'b0010 && reg_rdata_o[11:8] == 4'd15, "R8 fields kept",
        reg_rdata_o, 16'h0F12);
    rd(9, d);
    chk(d[9:0] == vin[1], "R8 original channel", d, vin[1]);
    clear_flag();

    // abort: no write, no flag
    keep4 = vin[4];
    wr(0, ctrl_word(1, 0, 0, 4, 0));
    wait_idle(cyc);
    clear_flag();
    vin[4] = ~keep4;
    wr(0, ctrl_word(1, 1, 0, 4, 2));
    repeat (8) @(negedge clk_i);
    wr(0, ctrl_word(0, 1, 0, 4, 2));
    chk(reg_rdata_o[0] == 1'b0, "R7 busy cleared", reg_rdata_o[0], 0);
    repeat (40) @(negedge clk_i);
    chk(reg_rdata_o[1] == 1'b0 && !irq_o, "R7 no flag", reg_rdata_o[1], 0);
    rd(12, d);
    chk(d[9:0] == keep4, "R7 no result", d, keep4);

    // scan pass over channels 0..3; channel 4 must keep old value
    for (int i = 0; i < 4; i++) vin[i] = 10'($urandom);
    scan_mon = 1'b1;
    wr(0, ctrl_word(1, 0, 1, 3, 0));
    cyc = 0;
    do begin
      rd(0, d);
      cyc++;
    end while (!d[1] && cyc < 2000);
    chk(d[0] == 1'b1, "R4 still busy after pass", d[0], 1);
    wr(0, ctrl_word(0, 0, 1, 3, 0));
    scan_mon = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd(8 + i, d);
      chk(d[9:0] == vin[i], "R4 scan result", d, vin[i]);
    end
    rd(12, d);
    chk(d[9:0] == keep4, "R4 R2 channel outside scan", d, keep4);
    chk(scan_bad == 0, "R4 ascending order", scan_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule